// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns the operand fields of a memory-addressing mode into an address. It adds an optional base register value, an optional index register value scaled by 1, 2, 4 or 8, and an optional signed displacement. The result is the effective offset. The unit then picks the segment register that governs the access and forms a 20-bit physical address: the 16-bit segment value shifted left by four bits, plus the offset.

A mode input selects 16-bit or 32-bit offset arithmetic. The segment is chosen from several inputs. An instruction fetch always uses the code segment. A string destination always uses the extra segment. A data access uses the stack segment when the base is the stack pointer or the frame pointer, and the data segment otherwise, unless an explicit override names another segment. The two auxiliary segments have no default use and are reachable only through an override.

The computation is combinational. Its result is captured in one register stage and marked by `out_valid` one cycle after `in_valid`. The six segment values arrive as plain inputs from the surrounding register file.

Top module: `eff_addr_gen`

## Requirements
- R1: `out_phys` equals (selected segment value × 16) plus the low 20 bits of `out_offset`, kept to 20 bits. Segment 123AH with offset 2234H gives 145D4H.
- R2: The offset is base + scaled index + displacement. A term whose enable is low (`base_en`, `idx_en`), or a displacement with size code 0, contributes zero whatever its value input holds.
- R3: In 32-bit mode (`mode32`=1), `scale_code` 0/1/2/3 multiplies the index by 1/2/4/8. In 16-bit mode the scale code is ignored and the index is added unscaled.
- R4: `disp_size` codes are: 0 none, 1 = bits 7:0 sign-extended, 2 = bits 15:0 sign-extended, 3 = all 32 bits. In 16-bit mode, code 3 behaves as code 2.
- R5: In 16-bit mode the offset sum wraps modulo 65536, and bits 31:16 of `out_offset` are zero.
- R6: The physical address sum wraps modulo 2^20 (1 MiB).
- R7: For a data access (`acc_kind` 0 or 3) with no override, the segment is SS when `base_en`=1 and `base_code` is 4 (stack pointer) or 5 (frame pointer). Otherwise the segment is DS.
- R8: `acc_kind`=1 (instruction fetch) selects CS, and `acc_kind`=2 (string destination) selects ES. Any override is ignored for these two kinds.
- R9: For a data access with `ovr_en`=1, `ovr_code` selects the segment: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. Codes 6 and 7 fall back to the default of R7. `out_seg` reports the segment with the same encoding.
- R10: `out_valid` is `in_valid` delayed by one clock. The outputs `out_offset`, `out_seg` and `out_phys` load only on a cycle with `in_valid`=1, and hold otherwise.
- R11: While `rst_n` is low, `out_valid`, `out_offset`, `out_seg` and `out_phys` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier; loads the output register |
| mode32 | input | 1 | 1 = 32-bit offset arithmetic, 0 = 16-bit |
| acc_kind | input | 2 | 0/3 data, 1 instruction fetch, 2 string destination |
| base_en | input | 1 | Base term present |
| base_code | input | 3 | Register number of the base (4 = stack pointer, 5 = frame pointer) |
| base_val | input | 32 | Base register value (instruction pointer for fetches) |
| idx_en | input | 1 | Index term present |
| idx_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale as a power of two |
| disp_size | input | 2 | Displacement size code |
| disp_val | input | 32 | Displacement bits |
| ovr_en | input | 1 | Segment override present |
| ovr_code | input | 3 | Segment named by the override |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| seg_fs | input | 16 | First auxiliary segment value |
| seg_gs | input | 16 | Second auxiliary segment value |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Effective offset |
| out_seg | output | 3 | Selected segment code |
| out_phys | output | 20 | Physical address |

## Verification
The hardest case to reach is the one where both wraps act at once. The 16-bit offset sum must overflow, or go negative through a sign-extended displacement, and the shifted segment plus that offset must then pass 1 MiB. Each is invisible unless the operands are chosen so the carry leaves the low field. The vector table therefore includes offsets near FFFFH with a segment of FFFFH, a negative 8-bit displacement against a zero base, and a 32-bit offset whose bits 19:0 overflow the physical adder. Overrides on fetch and string accesses, and the unused override codes, are driven with deliberately conflicting fields so that a wrong selection shows in `out_seg` and `out_phys`.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_e;

  typedef enum logic [1:0] {
    ACC_DATA   = 2'd0,
    ACC_FETCH  = 2'd1,
    ACC_STRDST = 2'd2,
    ACC_DATA2  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_B16  = 2'd2,
    DISP_B32  = 2'd3
  } disp_e;

  localparam logic [2:0] BASE_CODE_SP = 3'd4;
  localparam logic [2:0] BASE_CODE_BP = 3'd5;
  localparam int unsigned NUM_SEGS = 6;

endpackage

// File: rtl/eag_offset.sv
module eag_offset #(
  parameter int unsigned OFS_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             wide_mode,
  input  logic             base_en,
  input  logic [OFS_W-1:0] base_val,
  input  logic             idx_en,
  input  logic [OFS_W-1:0] idx_val,
  input  logic [1:0]       scale_code,
  input  logic [1:0]       disp_size,
  input  logic [OFS_W-1:0] disp_val,
  output logic [OFS_W-1:0] offset
);
  import eag_pkg::*;

  localparam int unsigned UPPER_W = OFS_W - NARROW_W;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] idx_term;
  logic [OFS_W-1:0] disp_term;
  logic [OFS_W-1:0] raw_sum;
  disp_e            eff_size;

  // A full-width displacement has no meaning in narrow mode; it acts as 16-bit.
  always_comb begin
    eff_size = disp_e'(disp_size);
    if (!wide_mode && eff_size == DISP_B32) begin
      eff_size = DISP_B16;
    end
  end

  always_comb begin
    unique case (eff_size)
      DISP_NONE: disp_term = '0;
      DISP_B8:   disp_term = {{(OFS_W-8){disp_val[7]}}, disp_val[7:0]};
      DISP_B16:  disp_term = {{(OFS_W-16){disp_val[15]}}, disp_val[15:0]};
      default:   disp_term = disp_val;
    endcase
  end

  always_comb begin
    base_term = base_en ? base_val : '0;
    if (!idx_en) begin
      idx_term = '0;
    end else if (wide_mode) begin
      idx_term = idx_val << scale_code;
    end else begin
      idx_term = idx_val;
    end
  end

  always_comb begin
    raw_sum = base_term + idx_term + disp_term;
    if (wide_mode) begin
      offset = raw_sum;
    end else begin
      offset = {{UPPER_W{1'b0}}, raw_sum[NARROW_W-1:0]};
    end
  end

endmodule

// File: rtl/eag_seg_select.sv
module eag_seg_select (
  input  logic [1:0] acc_kind,
  input  logic       base_en,
  input  logic [2:0] base_code,
  input  logic       ovr_en,
  input  logic [2:0] ovr_code,
  output logic [2:0] seg_sel
);
  import eag_pkg::*;

  seg_e dflt_seg;
  seg_e chosen;
  logic stack_base;
  logic ovr_legal;

  always_comb begin
    stack_base = base_en && (base_code == BASE_CODE_SP || base_code == BASE_CODE_BP);
    dflt_seg   = stack_base ? SEG_SS : SEG_DS;
    ovr_legal  = ovr_en && (ovr_code <= 3'(SEG_GS));
  end

  always_comb begin
    unique case (acc_e'(acc_kind))
      ACC_FETCH:  chosen = SEG_CS;
      ACC_STRDST: chosen = SEG_ES;
      default:    chosen = ovr_legal ? seg_e'(ovr_code) : dflt_seg;
    endcase
    seg_sel = chosen;
  end

  // The auxiliary segments can only come out of an explicit data override.
  always_comb begin
    if (seg_sel == SEG_FS || seg_sel == SEG_GS) begin
      assert_aux_needs_override_R9: assert (ovr_en && acc_kind != ACC_FETCH && acc_kind != ACC_STRDST)
        else $error("auxiliary segment chosen without a data override");
    end
  end

endmodule

// File: rtl/eag_phys.sv
module eag_phys #(
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned PHYS_W = 20
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFS_W-1:0]  offset,
  output logic [PHYS_W-1:0] phys
);
  localparam int unsigned SHIFT = PHYS_W - SEG_W;

  logic [PHYS_W-1:0] seg_base;
  logic [PHYS_W:0]   full_sum;

  always_comb begin
    seg_base = {seg_val, {SHIFT{1'b0}}};
    full_sum = {1'b0, seg_base} + {1'b0, offset[PHYS_W-1:0]};
    phys     = full_sum[PHYS_W-1:0];
  end

  // The shifted segment carries zeros below the shift, so the low bits pass straight through.
  always_comb begin
    assert_low_bits_pass_R1: assert (phys[SHIFT-1:0] == offset[SHIFT-1:0])
      else $error("physical low bits differ from offset low bits");
  end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int unsigned OFS_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned PHYS_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode32,
  input  logic [1:0]        acc_kind,
  input  logic              base_en,
  input  logic [2:0]        base_code,
  input  logic [OFS_W-1:0]  base_val,
  input  logic              idx_en,
  input  logic [OFS_W-1:0]  idx_val,
  input  logic [1:0]        scale_code,
  input  logic [1:0]        disp_size,
  input  logic [OFS_W-1:0]  disp_val,
  input  logic              ovr_en,
  input  logic [2:0]        ovr_code,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_ds,
  input  logic [SEG_W-1:0]  seg_fs,
  input  logic [SEG_W-1:0]  seg_gs,
  output logic              out_valid,
  output logic [OFS_W-1:0]  out_offset,
  output logic [2:0]        out_seg,
  output logic [PHYS_W-1:0] out_phys
);
  import eag_pkg::*;

  logic [OFS_W-1:0]  offset_c;
  logic [2:0]        seg_sel_c;
  logic [SEG_W-1:0]  seg_val_c;
  logic [PHYS_W-1:0] phys_c;
  logic [SEG_W-1:0]  seg_file [NUM_SEGS];

  logic              valid_d;
  logic [OFS_W-1:0]  offset_d;
  logic [2:0]        seg_d;
  logic [PHYS_W-1:0] phys_d;

  eag_offset #(
    .OFS_W    (OFS_W),
    .NARROW_W (NARROW_W)
  ) i_offset (
    .wide_mode  (mode32),
    .base_en    (base_en),
    .base_val   (base_val),
    .idx_en     (idx_en),
    .idx_val    (idx_val),
    .scale_code (scale_code),
    .disp_size  (disp_size),
    .disp_val   (disp_val),
    .offset     (offset_c)
  );

  eag_seg_select i_seg_select (
    .acc_kind  (acc_kind),
    .base_en   (base_en),
    .base_code (base_code),
    .ovr_en    (ovr_en),
    .ovr_code  (ovr_code),
    .seg_sel   (seg_sel_c)
  );

  always_comb begin
    seg_file[SEG_ES] = seg_es;
    seg_file[SEG_CS] = seg_cs;
    seg_file[SEG_SS] = seg_ss;
    seg_file[SEG_DS] = seg_ds;
    seg_file[SEG_FS] = seg_fs;
    seg_file[SEG_GS] = seg_gs;
    seg_val_c = (seg_sel_c < 3'(NUM_SEGS)) ? seg_file[seg_sel_c] : '0;
  end

  eag_phys #(
    .OFS_W  (OFS_W),
    .SEG_W  (SEG_W),
    .PHYS_W (PHYS_W)
  ) i_phys (
    .seg_val (seg_val_c),
    .offset  (offset_c),
    .phys    (phys_c)
  );

  // Next-state logic: the result fields load only under the request qualifier.
  always_comb begin
    valid_d  = in_valid;
    offset_d = out_offset;
    seg_d    = out_seg;
    phys_d   = out_phys;
    if (in_valid) begin
      offset_d = offset_c;
      seg_d    = seg_sel_c;
      phys_d   = phys_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_seg    <= '0;
      out_phys   <= '0;
    end else begin
      out_valid  <= valid_d;
      out_offset <= offset_d;
      out_seg    <= seg_d;
      out_phys   <= phys_d;
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid))
    else $error("out_valid is not in_valid delayed by one cycle");

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_offset) && $stable(out_phys) && $stable(out_seg)))
    else $error("outputs changed without a request");

  assert_fetch_code_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind == ACC_FETCH) |=> out_seg == SEG_CS)
    else $error("fetch did not select the code segment");

  assert_strdst_extra_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind == ACC_STRDST) |=> out_seg == SEG_ES)
    else $error("string destination did not select the extra segment");

  assert_narrow_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode32) |=> out_offset[OFS_W-1:NARROW_W] == '0)
    else $error("narrow-mode offset has upper bits set");

  assert_no_aux_without_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovr_en) |=> (out_seg != SEG_FS && out_seg != SEG_GS))
    else $error("auxiliary segment reported without override");

endmodule

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;

  typedef struct packed {
    logic        m32;
    logic [1:0]  kind;
    logic        ben;
    logic [2:0]  bcode;
    logic [31:0] bval;
    logic        ien;
    logic [31:0] ival;
    logic [1:0]  scale;
    logic [1:0]  dsz;
    logic [31:0] disp;
    logic        oen;
    logic [2:0]  ocode;
    logic [31:0] e_off;
    logic [2:0]  e_seg;
    logic [19:0] e_phys;
  } vec_t;

  localparam int NV = 14;
  // Segments used throughout: ES=1000 CS=2000 SS=3000 DS=123A FS=F000 GS=FFFF
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'd0,1'b1,3'd3,32'h2234,1'b0,32'h0,2'd0,2'd0,32'h0,1'b0,3'd0,32'h2234,3'd3,20'h145D4},        // R1 R7
    '{1'b0,2'd0,1'b1,3'd5,32'h10,1'b1,32'h20,2'd3,2'd1,32'hFE,1'b0,3'd0,32'h2E,3'd2,20'h3002E},          // R3 R4 R7
    '{1'b1,2'd0,1'b1,3'd3,32'h1000,1'b1,32'h10,2'd3,2'd2,32'h8000,1'b0,3'd0,32'hFFFF9080,3'd3,20'h0B420}, // R3 R4 R6
    '{1'b0,2'd0,1'b1,3'd6,32'hFFF0,1'b0,32'h0,2'd0,2'd2,32'h20,1'b0,3'd0,32'h10,3'd3,20'h123B0},         // R5
    '{1'b0,2'd0,1'b1,3'd5,32'h100,1'b0,32'h0,2'd0,2'd0,32'h0,1'b1,3'd4,32'h100,3'd4,20'hF0100},          // R9
    '{1'b0,2'd1,1'b1,3'd0,32'h5,1'b0,32'h0,2'd0,2'd0,32'h0,1'b1,3'd5,32'h5,3'd1,20'h20005},              // R8
    '{1'b0,2'd2,1'b1,3'd7,32'h40,1'b0,32'h0,2'd0,2'd0,32'h0,1'b1,3'd3,32'h40,3'd0,20'h10040},            // R8
    '{1'b0,2'd0,1'b1,3'd3,32'hFFFF,1'b0,32'h0,2'd0,2'd0,32'h0,1'b1,3'd5,32'hFFFF,3'd5,20'h0FFEF},        // R6 R9
    '{1'b1,2'd0,1'b0,3'd0,32'h0,1'b0,32'h0,2'd0,2'd3,32'h12345678,1'b0,3'd0,32'h12345678,3'd3,20'h57A18}, // R2 R4
    '{1'b1,2'd0,1'b1,3'd4,32'h100,1'b1,32'h3,2'd2,2'd1,32'h80,1'b0,3'd0,32'h8C,3'd2,20'h3008C},          // R3 R7
    '{1'b0,2'd0,1'b1,3'd3,32'h5,1'b0,32'h0,2'd0,2'd3,32'h1FFFF,1'b0,3'd0,32'h4,3'd3,20'h123A4},          // R4
    '{1'b1,2'd0,1'b1,3'd1,32'h10,1'b0,32'hFFFF,2'd1,2'd0,32'h0,1'b0,3'd0,32'h10,3'd3,20'h123B0},         // R2
    '{1'b0,2'd0,1'b1,3'd5,32'h20,1'b0,32'h0,2'd0,2'd0,32'h0,1'b1,3'd6,32'h20,3'd2,20'h30020},            // R9
    '{1'b0,2'd3,1'b1,3'd3,32'h0,1'b0,32'h0,2'd0,2'd1,32'hFF,1'b0,3'd0,32'hFFFF,3'd3,20'h2239F}           // R5 R7
  };

  logic        clk, rst_n, in_valid, mode32, base_en, idx_en, ovr_en;
  logic [1:0]  acc_kind, scale_code, disp_size;
  logic [2:0]  base_code, ovr_code;
  logic [31:0] base_val, idx_val, disp_val;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds, seg_fs, seg_gs;
  logic        out_valid;
  logic [31:0] out_offset;
  logic [2:0]  out_seg;
  logic [19:0] out_phys;

  int errors = 0;
  int checks = 0;

  eff_addr_gen i_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode32(mode32),
    .acc_kind(acc_kind), .base_en(base_en), .base_code(base_code),
    .base_val(base_val), .idx_en(idx_en), .idx_val(idx_val),
    .scale_code(scale_code), .disp_size(disp_size), .disp_val(disp_val),
    .ovr_en(ovr_en), .ovr_code(ovr_code),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_fs(seg_fs), .seg_gs(seg_gs),
    .out_valid(out_valid), .out_offset(out_offset), .out_seg(out_seg),
    .out_phys(out_phys)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid   = vld;
    mode32     = v.m32;
    acc_kind   = v.kind;
    base_en    = v.ben;
    base_code  = v.bcode;
    base_val   = v.bval;
    idx_en     = v.ien;
    idx_val    = v.ival;
    scale_code = v.scale;
    disp_size  = v.dsz;
    disp_val   = v.disp;
    ovr_en     = v.oen;
    ovr_code   = v.ocode;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000;
    seg_ds = 16'h123A; seg_fs = 16'hF000; seg_gs = 16'hFFFF;
    rst_n = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R11: everything zero in reset, even with a request pending
    in_valid = 1'b1;
    @(negedge clk);
    chk("R11 valid", {31'b0, out_valid}, 32'h0);
    chk("R11 offset", out_offset, 32'h0);
    chk("R11 seg", {29'b0, out_seg}, 32'h0);
    chk("R11 phys", {12'b0, out_phys}, 32'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: one request per cycle, result sampled one edge later
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      chk($sformatf("R10 vec%0d valid", i), {31'b0, out_valid}, 32'h1);
      chk($sformatf("R2 vec%0d offset", i), out_offset, VECS[i].e_off);
      chk($sformatf("R7 vec%0d seg", i), {29'b0, out_seg}, {29'b0, VECS[i].e_seg});
      chk($sformatf("R1 vec%0d phys", i), {12'b0, out_phys}, {12'b0, VECS[i].e_phys});
    end

    // R10: idle cycle with different fields must not disturb the result
    drive(VECS[2], 1'b0);
    @(negedge clk);
    chk("R10 idle valid", {31'b0, out_valid}, 32'h0);
    chk("R10 hold offset", out_offset, VECS[NV-1].e_off);
    chk("R10 hold phys", {12'b0, out_phys}, {12'b0, VECS[NV-1].e_phys});
    chk("R10 hold seg", {29'b0, out_seg}, {29'b0, VECS[NV-1].e_seg});
    // Segment value change alone, still idle: no effect
    seg_ds = 16'h0000;
    @(negedge clk);
    chk("R10 hold phys2", {12'b0, out_phys}, {12'b0, VECS[NV-1].e_phys});
    seg_ds = 16'h123A;

    // R6 corner: GS=FFFF with offset FFFF through 32-bit mode
    drive(VECS[7], 1'b1);
    mode32 = 1'b1;
    @(negedge clk);
    chk("R6 wide wrap phys", {12'b0, out_phys}, 32'h0FFEF);
    in_valid = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule